// File: doc/BRIEF.md
# Direct-Mapped Write-Back Line Cache

This block is a direct-mapped, write-back cache whose unit of transfer is a whole line of eight 64-bit words (64 bytes). A requester issues one command at a time on a valid/ready command port. There are three commands. Initialize invalidates every entry. Access reads and/or writes a resident line and reports hit or miss. Insert fills a line and hands back any dirty line it displaces.

An access never allocates, and a miss leaves the cache untouched. The surrounding controller fetches the line from the next level on its own and then issues an insert. When the victim of an insert is valid and dirty, the response carries that victim's data and its rebuilt line address, so the controller can write it back.

Only the low 48 address bits take part. The index width is a parameter and the tag takes the remaining used bits, so a small instance can be exercised exhaustively.

Top module: `line_cache`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0 and every entry is invalid, so any access misses.
- R2: The index is address bits [6 +: INDEX_W], the tag is bits 47 down to 6+INDEX_W, bits 5:0 are a byte offset, and bits 63:48 and 5:0 never change a result.
- R3: A command accepted when cmd_valid and cmd_ready are both 1 (other than initialize) produces rsp_valid for exactly the following cycle. For access (cmd_op=1), rsp_status is 1 only if the indexed entry is valid and its tag equals the address tag.
- R4: A missed access changes no entry. Its response has rsp_status 0, and rsp_rline, rsp_wb_addr and rsp_wb_line are all zero.
- R5: cmd_ctrl bit 0 is read enable. On a hit with it set, rsp_rline returns all eight words, word i at bits [64*i +: 64]. With it clear, rsp_rline is zero.
- R6: cmd_ctrl bit 1 is write enable. On a hit with it set, the whole line is replaced by cmd_wline and the entry becomes dirty.
- R7: With both enables set on a hit, rsp_rline carries the line as it was before the write.
- R8: Insert (cmd_op=2) on a valid, dirty entry gives rsp_status 1. It also returns the old line on rsp_wb_line and {16'b0, old tag, index, 6'b0} on rsp_wb_addr. On any other entry, rsp_status is 0 and both write-back outputs are zero.
- R9: After insert, the entry is valid and clean and holds the new tag and the line from cmd_wline.
- R10: Initialize (cmd_op=0) holds cmd_ready low for 2^INDEX_W cycles after acceptance, clearing one entry per cycle. rsp_valid (with rsp_status 0) and cmd_ready return together in the next cycle. Afterwards every entry is invalid and clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_op | input | 2 | 0 initialize, 1 access, 2 insert |
| cmd_addr | input | 64 | Byte address inside the target line |
| cmd_ctrl | input | 2 | Bit 0 read enable, bit 1 write enable (access only) |
| cmd_wline | input | 512 | Line to write or insert |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_status | output | 1 | Access: hit. Insert: write-back needed |
| rsp_rline | output | 512 | Line read by an access |
| rsp_wb_addr | output | 64 | Line address of the evicted dirty line |
| rsp_wb_line | output | 512 | Data of the evicted dirty line |

## Verification
The hardest case to reach is a dirty victim whose rebuilt address must match exactly. Getting there takes an insert, then an access with write enable that hits, then a second insert with a different tag at the same index. The bench runs this chain at every index of a 16-entry instance. It puts junk in address bits 63:48 and 5:0 so that any leak of them into the tag, the index or the write-back address shows up. It then checks that an initialize undoes all of it, including the dirty bits.

// File: rtl/lc_pkg.sv
package lc_pkg;
    localparam int LC_WORDS  = 8;
    localparam int LC_WORD_W = 64;
    localparam int LC_LINE_W = LC_WORDS * LC_WORD_W;
    localparam int LC_ADDR_W = 64;
    localparam int LC_USED_W = 48;
    localparam int LC_OFF_W  = 6;

    typedef enum logic [1:0] {
        LC_OP_INIT   = 2'd0,
        LC_OP_ACCESS = 2'd1,
        LC_OP_INSERT = 2'd2
    } lc_op_e;

    typedef enum logic {
        LC_IDLE  = 1'b0,
        LC_SWEEP = 1'b1
    } lc_fsm_e;
endpackage

// File: rtl/lc_addr_split.sv
module lc_addr_split #(
    parameter int ADDR_W  = 64,
    parameter int USED_W  = 48,
    parameter int OFF_W   = 6,
    parameter int INDEX_W = 4,
    localparam int TAG_W  = USED_W - OFF_W - INDEX_W
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [INDEX_W-1:0] index,
    output logic [TAG_W-1:0]   tag
);
    // Bits above USED_W and the byte offset play no part.
    assign index = addr[OFF_W +: INDEX_W];
    assign tag   = addr[OFF_W + INDEX_W +: TAG_W];
endmodule

// File: rtl/lc_store.sv
module lc_store #(
    parameter int INDEX_W = 4,
    parameter int TAG_W   = 38,
    parameter int LINE_W  = 512,
    localparam int DEPTH  = 1 << INDEX_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [INDEX_W-1:0] rd_idx,
    output logic               rd_valid,
    output logic               rd_dirty,
    output logic [TAG_W-1:0]   rd_tag,
    output logic [LINE_W-1:0]  rd_line,
    input  logic               wr_en,
    input  logic [INDEX_W-1:0] wr_idx,
    input  logic               wr_valid,
    input  logic               wr_dirty,
    input  logic [TAG_W-1:0]   wr_tag,
    input  logic               wr_line_en,
    input  logic [LINE_W-1:0]  wr_line
);
    logic [DEPTH-1:0]  valid_q;
    logic [DEPTH-1:0]  dirty_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];
    logic [LINE_W-1:0] line_q [DEPTH];

    assign rd_valid = valid_q[rd_idx];
    assign rd_dirty = dirty_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_line  = line_q[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
            for (int i = 0; i < DEPTH; i++) tag_q[i] <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_valid;
            dirty_q[wr_idx] <= wr_dirty;
            tag_q[wr_idx]   <= wr_tag;
        end
    end

    // Line storage needs no reset: valid gates every use of it.
    always_ff @(posedge clk) begin
        if (wr_en && wr_line_en) line_q[wr_idx] <= wr_line;
    end
endmodule

// File: rtl/line_cache.sv
module line_cache
    import lc_pkg::*;
#(
    parameter int INDEX_W = 4,
    localparam int TAG_W  = LC_USED_W - LC_OFF_W - INDEX_W,
    localparam int DEPTH  = 1 << INDEX_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    output logic                 cmd_ready,
    input  logic [1:0]           cmd_op,
    input  logic [LC_ADDR_W-1:0] cmd_addr,
    input  logic [1:0]           cmd_ctrl,
    input  logic [LC_LINE_W-1:0] cmd_wline,
    output logic                 rsp_valid,
    output logic                 rsp_status,
    output logic [LC_LINE_W-1:0] rsp_rline,
    output logic [LC_ADDR_W-1:0] rsp_wb_addr,
    output logic [LC_LINE_W-1:0] rsp_wb_line
);
    typedef struct packed {
        lc_fsm_e              fsm;
        logic [INDEX_W-1:0]   cnt;
        logic                 rsp_valid;
        logic                 rsp_status;
        logic [LC_LINE_W-1:0] rline;
        logic [LC_ADDR_W-1:0] wb_addr;
        logic [LC_LINE_W-1:0] wb_line;
    } lc_state_t;

    lc_state_t state_d, state_q;

    logic [INDEX_W-1:0]   a_idx;
    logic [TAG_W-1:0]     a_tag;
    logic                 e_valid, e_dirty;
    logic [TAG_W-1:0]     e_tag;
    logic [LC_LINE_W-1:0] e_line;
    logic                 w_en, w_valid, w_dirty, w_line_en;
    logic [INDEX_W-1:0]   w_idx;
    logic [TAG_W-1:0]     w_tag;
    logic                 fire, hit;

    lc_addr_split #(
        .ADDR_W (LC_ADDR_W),
        .USED_W (LC_USED_W),
        .OFF_W  (LC_OFF_W),
        .INDEX_W(INDEX_W)
    ) u_split (
        .addr (cmd_addr),
        .index(a_idx),
        .tag  (a_tag)
    );

    lc_store #(
        .INDEX_W(INDEX_W),
        .TAG_W  (TAG_W),
        .LINE_W (LC_LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_idx    (a_idx),
        .rd_valid  (e_valid),
        .rd_dirty  (e_dirty),
        .rd_tag    (e_tag),
        .rd_line   (e_line),
        .wr_en     (w_en),
        .wr_idx    (w_idx),
        .wr_valid  (w_valid),
        .wr_dirty  (w_dirty),
        .wr_tag    (w_tag),
        .wr_line_en(w_line_en),
        .wr_line   (cmd_wline)
    );

    assign cmd_ready = (state_q.fsm == LC_IDLE);
    assign fire      = cmd_valid && cmd_ready;
    assign hit       = e_valid && (e_tag == a_tag);

    always_comb begin
        state_d            = state_q;
        state_d.rsp_valid  = 1'b0;
        state_d.rsp_status = 1'b0;
        state_d.rline      = '0;
        state_d.wb_addr    = '0;
        state_d.wb_line    = '0;
        w_en      = 1'b0;
        w_idx     = a_idx;
        w_valid   = 1'b0;
        w_dirty   = 1'b0;
        w_tag     = a_tag;
        w_line_en = 1'b0;

        if (state_q.fsm == LC_SWEEP) begin
            w_en  = 1'b1;
            w_idx = state_q.cnt;
            w_tag = '0;
            if (state_q.cnt == INDEX_W'(DEPTH - 1)) begin
                state_d.fsm       = LC_IDLE;
                state_d.rsp_valid = 1'b1;
            end else begin
                state_d.cnt = state_q.cnt + 1'b1;
            end
        end else if (fire) begin
            unique case (lc_op_e'(cmd_op))
                LC_OP_INIT: begin
                    state_d.fsm = LC_SWEEP;
                    state_d.cnt = '0;
                end
                LC_OP_ACCESS: begin
                    state_d.rsp_valid  = 1'b1;
                    state_d.rsp_status = hit;
                    if (hit && cmd_ctrl[0]) state_d.rline = e_line;
                    if (hit && cmd_ctrl[1]) begin
                        w_en      = 1'b1;
                        w_valid   = 1'b1;
                        w_dirty   = 1'b1;
                        w_tag     = e_tag;
                        w_line_en = 1'b1;
                    end
                end
                LC_OP_INSERT: begin
                    state_d.rsp_valid = 1'b1;
                    if (e_valid && e_dirty) begin
                        state_d.rsp_status = 1'b1;
                        state_d.wb_line    = e_line;
                        state_d.wb_addr    = {{(LC_ADDR_W - LC_USED_W){1'b0}},
                                              e_tag, a_idx, {LC_OFF_W{1'b0}}};
                    end
                    w_en      = 1'b1;
                    w_valid   = 1'b1;
                    w_dirty   = 1'b0;
                    w_tag     = a_tag;
                    w_line_en = 1'b1;
                end
                default: state_d.rsp_valid = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q     <= '0;
            state_q.fsm <= LC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid   = state_q.rsp_valid;
    assign rsp_status  = state_q.rsp_status;
    assign rsp_rline   = state_q.rline;
    assign rsp_wb_addr = state_q.wb_addr;
    assign rsp_wb_line = state_q.wb_line;

    // R3: every non-initialize command is answered in the next cycle
    p_rsp_follows_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op != 2'd0) |=> rsp_valid);

    // R3: no response appears without a command or a finishing sweep
    p_no_stray_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire && state_q.fsm == LC_IDLE) |=> !rsp_valid);

    // R8: a write-back address is line aligned and inside the used range
    p_wb_addr_aligned_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_wb_addr[LC_OFF_W-1:0] == '0 &&
                       rsp_wb_addr[LC_ADDR_W-1:LC_USED_W] == '0));

    // R4: a response with status 0 carries no line data
    p_miss_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_status) |-> (rsp_rline == '0 && rsp_wb_line == '0));

    // R10: accepting initialize stalls the command port
    p_init_stalls_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && cmd_op == 2'd0) |=> !cmd_ready);
endmodule

// File: tb/sim_line_cache.sv
module sim_line_cache;
    localparam int IW = 4;
    localparam int N  = 1 << IW;
    localparam int TW = 48 - 6 - IW;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cmd_valid = 1'b0;
    logic         cmd_ready;
    logic [1:0]   cmd_op = '0;
    logic [63:0]  cmd_addr = '0;
    logic [1:0]   cmd_ctrl = '0;
    logic [511:0] cmd_wline = '0;
    logic         rsp_valid, rsp_status;
    logic [511:0] rsp_rline, rsp_wb_line;
    logic [63:0]  rsp_wb_addr;

    int checks = 0;
    int fails  = 0;

    bit            m_valid [N];
    bit            m_dirty [N];
    logic [TW-1:0] m_tag   [N];
    logic [511:0]  m_line  [N];

    always #10 clk = ~clk;

    line_cache #(.INDEX_W(IW)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_addr(cmd_addr), .cmd_ctrl(cmd_ctrl),
        .cmd_wline(cmd_wline), .rsp_valid(rsp_valid), .rsp_status(rsp_status),
        .rsp_rline(rsp_rline), .rsp_wb_addr(rsp_wb_addr), .rsp_wb_line(rsp_wb_line)
    );

    task automatic check(input string req, input logic [511:0] act, input logic [511:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [511:0] pat(input int a, input int b);
        logic [511:0] r;
        for (int w = 0; w < 8; w++) r[64*w +: 64] = {16'hC0DE, 8'(a), 8'(b), 32'(w * 32'h01010101 + a)};
        return r;
    endfunction

    // Address with junk in bits 63:48 and 5:0 (R2)
    function automatic logic [63:0] mk_addr(input logic [TW-1:0] tg, input int idx, input int junk);
        return {16'(junk * 16'h1357), tg, IW'(idx), 6'(junk)};
    endfunction

    task automatic issue(input logic [1:0] op, input logic [63:0] a,
                         input logic [1:0] c, input logic [511:0] wl);
        cmd_op = op; cmd_addr = a; cmd_ctrl = c; cmd_wline = wl; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic do_access(input logic [TW-1:0] tg, input int idx, input int junk,
                             input logic [1:0] c, input logic [511:0] wl);
        bit h;
        logic [511:0] er;
        h  = m_valid[idx] && (m_tag[idx] == tg);
        er = (h && c[0]) ? m_line[idx] : '0;
        issue(2'd1, mk_addr(tg, idx, junk), c, wl);
        check("R3 rsp_valid", 512'(rsp_valid), 512'(1));
        check(h ? "R3 hit" : "R4 miss", 512'(rsp_status), 512'(h));
        check(c == 2'b11 ? "R7 rline" : (h ? "R5 rline" : "R4 rline"), rsp_rline, er);
        check("R4 wb_addr", 512'(rsp_wb_addr), 512'(0));
        if (h && c[1]) begin
            m_line[idx]  = wl;
            m_dirty[idx] = 1'b1;
        end
    endtask

    task automatic do_insert(input logic [TW-1:0] tg, input int idx, input int junk,
                             input logic [511:0] wl);
        bit wb;
        logic [63:0] ea;
        wb = m_valid[idx] && m_dirty[idx];
        ea = wb ? {16'h0, m_tag[idx], IW'(idx), 6'h0} : 64'h0;
        issue(2'd2, mk_addr(tg, idx, junk), 2'b00, wl);
        check("R8 status", 512'(rsp_status), 512'(wb));
        check("R8 wb_addr", 512'(rsp_wb_addr), 512'(ea));
        check("R8 wb_line", rsp_wb_line, wb ? m_line[idx] : 512'h0);
        m_valid[idx] = 1'b1; m_dirty[idx] = 1'b0; m_tag[idx] = tg; m_line[idx] = wl;
    endtask

    task automatic do_init();
        int lows = 0;
        issue(2'd0, 64'h0, 2'b00, '0);
        while (!rsp_valid && lows < 4 * N) begin
            check("R10 ready low", 512'(cmd_ready), 512'(0));
            lows++;
            @(negedge clk);
        end
        check("R10 sweep length", 512'(lows), 512'(N));
        check("R10 ready back", 512'(cmd_ready), 512'(1));
        check("R10 status", 512'(rsp_status), 512'(0));
        for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; end
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) begin m_valid[i] = 1'b0; m_dirty[i] = 1'b0; m_tag[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 ready", 512'(cmd_ready), 512'(1));
        check("R1 rsp_valid", 512'(rsp_valid), 512'(0));
        do_access('0, 0, 0, 2'b01, '0);
        do_access(TW'(5), 3, 7, 2'b11, pat(9, 9));

        for (int i = 0; i < N; i++) begin
            logic [TW-1:0] ta, tb;
            ta = TW'(i * 3 + 1);
            tb = ta ^ TW'(1 << (TW - 1));
            do_insert(ta, i, i, pat(i, 1));                  // R9 fill
            do_access(ta, i, i + 5, 2'b01, '0);              // R5 read hit
            do_access(tb, i, i, 2'b11, pat(i, 7));           // R4 miss, no write
            do_access(ta, i, 63, 2'b01, '0);                 // R4 line unchanged
            if (i % 2 == 0) do_access(ta, i, 1, 2'b11, pat(i, 2));  // R7 + R6
            else            do_access(ta, i, 2, 2'b10, pat(i, 3));  // R6 write only
            do_access(ta, i, 4, 2'b00, '0);                  // R5 no read
            do_access(ta, i, 0, 2'b01, '0);                  // R6 new data
            do_insert(tb, i, 9, pat(i, 4));                  // R8 dirty victim
            do_insert(ta, i, 3, pat(i, 5));                  // R9 clean: no wb
            do_access(ta, i, 0, 2'b01, '0);                  // R9 new tag hits
        end

        for (int i = 0; i < N; i += 3) do_access(TW'(i * 3 + 1), i, 0, 2'b10, pat(i, 6));
        do_init();
        for (int i = 0; i < N; i++) begin
            do_access(TW'(i * 3 + 1), i, 0, 2'b01, '0);      // R10 all invalid
            do_insert(TW'(i), i, 0, pat(i, 8));              // R10 dirty cleared
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule